// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits beside a processor that announces each bus transfer ahead of time on a 3-bit status code. The decoder watches that code and drives the active-low command strobes that memory and I/O devices need: memory read, memory write (normal and advanced), I/O read, I/O write (normal and advanced) and interrupt acknowledge. It also drives the address latch pulse, the data direction line and the data buffer enable.

A transfer begins when the status changes from the passive code to a code that names a transfer. The first clock of the transfer pulses the address latch strobe. In the second clock the read-type strobes, the interrupt acknowledge strobe and the advanced write strobes go active. The normal write strobes follow one clock later. Every strobe is held until the status returns to the passive code, and that ends the transfer. The command type is fixed by the code seen at the start. The halt code starts nothing.

All outputs are functions of registered state, so they change only just after a rising clock edge.

Top module: `bus_cmd_decoder`

## Requirements
- R1: While reset is low, every command strobe is high and the latch pulse, data enable and direction outputs are low. After reset, no transfer begins until the status has been sampled as 111 on at least one clock edge.
- R2: In the idle state, a rising edge that samples a status other than 111 and 011 starts a transfer. The latch pulse is high for exactly the one clock that follows that edge, and no command strobe is active during that clock.
- R3: The status is read as S2S1S0 with S2 the most significant bit. The codes map as follows: 000 drives interrupt acknowledge, 001 drives I/O read, 010 drives both I/O writes, 100 (fetch) and 101 (data read) drive memory read, and 110 drives both memory writes.
- R4: The read strobes, the interrupt acknowledge strobe and the advanced write strobes are active from the second clock of a transfer. The normal write strobes are active from the third clock. All of them then stay active until the transfer ends.
- R5: Data enable is high from the second clock of a transfer until it ends. The direction output is high for the whole of a write transfer, including the latch clock, and low for reads and interrupt acknowledge.
- R6: A rising edge that samples status 111 ends any transfer. After that edge all strobes are high and data enable and direction are low. If 111 is sampled during the latch clock, the transfer ends without any strobe going active.
- R7: The command is taken from the code sampled when the transfer starts. Later non-passive codes seen before 111 have no effect on the strobes.
- R8: Status 011 (halt) produces no latch pulse and no strobe. After a halt, no transfer begins until 111 has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat | input | 3 | Bus status code S2S1S0 |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Normal memory write strobe, active low |
| mem_wr_adv_n | output | 1 | Advanced memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | Normal I/O write strobe, active low |
| io_wr_adv_n | output | 1 | Advanced I/O write strobe, active low |
| int_ack_n | output | 1 | Interrupt acknowledge strobe, active low |
| ale | output | 1 | Address latch pulse |
| dt_r | output | 1 | Data direction, high while transmitting |
| den | output | 1 | Data buffer enable |

## Verification
The bench walks every status code through the latch clock, the leading clock and the full-command clock, and then returns the status to passive. This catches a swapped decode entry and a write strobe that goes active together with its advanced strobe instead of one clock later. Directed cases cover several faults. A status held non-passive through reset release must not start a transfer; an edge-blind design would start one. A status switched in the middle of a transfer must not change the command; a design that decodes the live code would flip strobes. A passive code during the latch clock must suppress all strobes; a design with a fixed sequence would still fire them. A halt followed directly by a transfer code must stay quiet until passive is seen. Asserting reset in the middle of a transfer must release every strobe at once.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    localparam int STAT_W = 3;

    typedef enum logic [STAT_W-1:0] {
        ST_INTA  = 3'b000,
        ST_IORD  = 3'b001,
        ST_IOWR  = 3'b010,
        ST_HALT  = 3'b011,
        ST_FETCH = 3'b100,
        ST_MRD   = 3'b101,
        ST_MWR   = 3'b110,
        ST_PASS  = 3'b111
    } stat_e;

    // Transfer phases: waiting for passive, armed, latch clock,
    // leading-strobe clock, full-command clocks
    typedef enum logic [2:0] {
        PH_WAITP,
        PH_IDLE,
        PH_ADDR,
        PH_LEAD,
        PH_FULL
    } phase_e;

    // Active-high command selection for a latched code
    typedef struct packed {
        logic mrd;
        logic mwr;
        logic iord;
        logic iowr;
        logic inta;
        logic wr;
    } cmd_sel_t;

    typedef struct packed {
        phase_e              phase;
        logic [STAT_W-1:0]   code;
    } seq_t;

endpackage

// File: rtl/bcd_cmd_map.sv
module bcd_cmd_map
    import bcd_pkg::*;
(
    input  logic [STAT_W-1:0] code,
    output cmd_sel_t          sel
);

    always_comb begin
        sel = '0;
        case (code)
            ST_INTA:  sel.inta = 1'b1;
            ST_IORD:  sel.iord = 1'b1;
            ST_IOWR:  begin sel.iowr = 1'b1; sel.wr = 1'b1; end
            ST_FETCH: sel.mrd  = 1'b1;
            ST_MRD:   sel.mrd  = 1'b1;
            ST_MWR:   begin sel.mwr = 1'b1; sel.wr = 1'b1; end
            default:  sel = '0;
        endcase
    end

endmodule

// File: rtl/bcd_seq.sv
module bcd_seq
    import bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat,
    output phase_e            phase,
    output logic [STAT_W-1:0] code
);

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (stat == ST_PASS) begin
            s_d.phase = PH_IDLE;
        end else begin
            case (s_q.phase)
                PH_WAITP: s_d.phase = PH_WAITP;
                PH_IDLE: begin
                    if (stat == ST_HALT) begin
                        s_d.phase = PH_WAITP;
                    end else begin
                        s_d.phase = PH_ADDR;
                        s_d.code  = stat;
                    end
                end
                PH_ADDR: s_d.phase = PH_LEAD;
                PH_LEAD: s_d.phase = PH_FULL;
                PH_FULL: s_d.phase = PH_FULL;
                default: s_d.phase = PH_WAITP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_WAITP;
            s_q.code  <= ST_PASS;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase = s_q.phase;
    assign code  = s_q.code;

endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
    import bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              mem_wr_adv_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic              io_wr_adv_n,
    output logic              int_ack_n,
    output logic              ale,
    output logic              dt_r,
    output logic              den
);

    phase_e            phase;
    logic [STAT_W-1:0] code_q;
    cmd_sel_t          sel;
    logic              in_xfer, lead_on, full_on;

    bcd_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .stat  (stat),
        .phase (phase),
        .code  (code_q)
    );

    bcd_cmd_map u_map (
        .code (code_q),
        .sel  (sel)
    );

    always_comb begin
        lead_on = (phase == PH_LEAD) || (phase == PH_FULL);
        full_on = (phase == PH_FULL);
        in_xfer = (phase == PH_ADDR) || lead_on;

        ale          = (phase == PH_ADDR);
        den          = lead_on;
        dt_r         = in_xfer & sel.wr;
        mem_rd_n     = ~(lead_on & sel.mrd);
        mem_wr_adv_n = ~(lead_on & sel.mwr);
        mem_wr_n     = ~(full_on & sel.mwr);
        io_rd_n      = ~(lead_on & sel.iord);
        io_wr_adv_n  = ~(lead_on & sel.iowr);
        io_wr_n      = ~(full_on & sel.iowr);
        int_ack_n    = ~(lead_on & sel.inta);
    end

endmodule

// File: rtl/bcd_checker.sv
module bcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] stat,
    input logic       mem_rd_n,
    input logic       mem_wr_n,
    input logic       mem_wr_adv_n,
    input logic       io_rd_n,
    input logic       io_wr_n,
    input logic       io_wr_adv_n,
    input logic       int_ack_n,
    input logic       ale,
    input logic       dt_r,
    input logic       den
);

    logic [6:0] low_cmds;
    assign low_cmds = ~{mem_rd_n, mem_wr_n, mem_wr_adv_n, io_rd_n,
                        io_wr_n, io_wr_adv_n, int_ack_n};

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (low_cmds == '0 && !ale && !den && !dt_r); // R1
        end
    end

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale); // R2

    AST_ALE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> ($past(stat) != 3'b111 && $past(stat) != 3'b011)); // R8

    AST_ALE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (low_cmds == '0 && !den)); // R2

    AST_WR_AFTER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> $past(!mem_wr_adv_n)); // R4

    AST_IOWR_AFTER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_wr_n) |-> $past(!io_wr_adv_n)); // R4

    AST_PASSIVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == 3'b111) |=> (low_cmds == '0 && !den && !dt_r)); // R6

    AST_CMD_NEEDS_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        (low_cmds != '0) |-> den); // R5

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~mem_rd_n, ~mem_wr_adv_n, ~io_rd_n, ~io_wr_adv_n, ~int_ack_n}) <= 1); // R3

endmodule

bind bus_cmd_decoder bcd_checker u_bcd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .stat         (stat),
    .mem_rd_n     (mem_rd_n),
    .mem_wr_n     (mem_wr_n),
    .mem_wr_adv_n (mem_wr_adv_n),
    .io_rd_n      (io_rd_n),
    .io_wr_n      (io_wr_n),
    .io_wr_adv_n  (io_wr_adv_n),
    .int_ack_n    (int_ack_n),
    .ale          (ale),
    .dt_r         (dt_r),
    .den          (den)
);

// File: tb/tb_bus_cmd_decoder.sv
`timescale 1ns/1ps
module tb_bus_cmd_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] stat = 3'b101;
    logic       mem_rd_n, mem_wr_n, mem_wr_adv_n, io_rd_n, io_wr_n, io_wr_adv_n;
    logic       int_ack_n, ale, dt_r, den;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bus_cmd_decoder dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .stat         (stat),
        .mem_rd_n     (mem_rd_n),
        .mem_wr_n     (mem_wr_n),
        .mem_wr_adv_n (mem_wr_adv_n),
        .io_rd_n      (io_rd_n),
        .io_wr_n      (io_wr_n),
        .io_wr_adv_n  (io_wr_adv_n),
        .int_ack_n    (int_ack_n),
        .ale          (ale),
        .dt_r         (dt_r),
        .den          (den)
    );

    // Vector: {code, write flag, strobes at full command}
    // strobe order {mrd, mwr, amwr, iord, iowr, aiowr, inta}, active low
    localparam logic [10:0] VEC [8] = '{
        {3'b000, 1'b0, 7'b1111110},
        {3'b001, 1'b0, 7'b1110111},
        {3'b010, 1'b1, 7'b1111001},
        {3'b011, 1'b0, 7'b1111111},
        {3'b100, 1'b0, 7'b0111111},
        {3'b101, 1'b0, 7'b0111111},
        {3'b110, 1'b1, 7'b1001111},
        {3'b111, 1'b0, 7'b1111111}
    };
    localparam logic [6:0] NORM_WR = 7'b0100100;
    localparam logic [9:0] IDLE_OUT = {3'b000, 7'b1111111};

    function automatic logic [9:0] observed();
        return {ale, den, dt_r, mem_rd_n, mem_wr_n, mem_wr_adv_n,
                io_rd_n, io_wr_n, io_wr_adv_n, int_ack_n};
    endfunction

    task automatic check(input logic [9:0] exp, input string tag);
        logic [9:0] got;
        got = observed();
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, with a transfer code present
        repeat (3) @(negedge clk);
        check(IDLE_OUT, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk); check(IDLE_OUT, "R1 no start before passive");
        @(negedge clk); check(IDLE_OUT, "R1 no start before passive");
        stat = 3'b111;
        @(negedge clk); check(IDLE_OUT, "R1 armed idle");

        // R2 R3 R4 R5 R6 R8: every code through each phase
        for (int i = 0; i < 8; i++) begin
            logic [2:0] c;
            logic       w;
            logic [6:0] p;
            {c, w, p} = VEC[i];
            stat = c;
            if (c == 3'b011 || c == 3'b111) begin
                @(negedge clk); check(IDLE_OUT, "R8 no cycle clk1");
                @(negedge clk); check(IDLE_OUT, "R8 no cycle clk2");
                @(negedge clk); check(IDLE_OUT, "R8 no cycle clk3");
            end else begin
                @(negedge clk); check({1'b1, 1'b0, w, 7'b1111111}, "R2 latch clock");
                @(negedge clk); check({1'b0, 1'b1, w, p | NORM_WR}, "R4 lead clock");
                @(negedge clk); check({1'b0, 1'b1, w, p}, "R3 full command");
            end
            stat = 3'b111;
            @(negedge clk); check(IDLE_OUT, "R6 passive ends");
        end

        // R7: code change mid-transfer ignored
        stat = 3'b101;
        @(negedge clk); check({3'b100, 7'b1111111}, "R7 latch clock");
        stat = 3'b000;
        @(negedge clk); check({3'b010, 7'b0111111}, "R7 lead after change");
        stat = 3'b110;
        @(negedge clk); check({3'b010, 7'b0111111}, "R7 full after change");
        stat = 3'b111;
        @(negedge clk); check(IDLE_OUT, "R6 end");

        // R6: passive during latch clock aborts
        stat = 3'b110;
        @(negedge clk); check({3'b101, 7'b1111111}, "R5 write latch clock");
        stat = 3'b111;
        @(negedge clk); check(IDLE_OUT, "R6 abort");
        @(negedge clk); check(IDLE_OUT, "R6 abort stays quiet");

        // R8: halt then transfer code without passive
        stat = 3'b011;
        @(negedge clk); check(IDLE_OUT, "R8 halt");
        stat = 3'b101;
        @(negedge clk); check(IDLE_OUT, "R8 blocked after halt");
        @(negedge clk); check(IDLE_OUT, "R8 blocked after halt");
        stat = 3'b111;
        @(negedge clk); check(IDLE_OUT, "R8 re-armed");
        stat = 3'b001;
        @(negedge clk); check({3'b100, 7'b1111111}, "R8 start after passive");
        @(negedge clk); check({3'b010, 7'b1110111}, "R3 io read");

        // R1: reset in the middle of a transfer
        stat = 3'b010;
        @(negedge clk);
        rst_n = 1'b0;
        #1 check(IDLE_OUT, "R1 reset mid transfer");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); check(IDLE_OUT, "R1 needs passive after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule